// File: doc/BRIEF.md
# Reset cause status register

This block is a 16-bit control and status register that remembers why the device last came out of reset. Each reset source delivers a one-cycle strobe, and the strobe latches a sticky flag. The flag stays set through every later reset except a power-on, so firmware can read the cause once it is running again. The same register also holds three control bits: a software watchdog enable, a software brown-out enable and a bit that keeps program memory powered during sleep.

Two configuration-fuse inputs can override the software enables. A watchdog fuse at 1 forces the watchdog on. The brown-out mode field decides whether the software brown-out bit is used at all, and it also sets that bit's value at power-on. Software uses a plain register port: a write strobe and write data in, read data out. The block's synchronous reset input is the power-on event.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads its power-on value: bits 1 (brown-out flag) and 0 (power-on flag) become 1, and every other bit becomes 0. The one exception is bit 13, which becomes 1 when `bor_mode` is 2'b01. A reset strobe raised in the same cycle as `rst` is overridden.
- R2: An event strobe that is high at a clock edge sets its flag, and `rd_data` shows the flag from that edge on. The strobes map to bits as follows: `ev_trap` 15, `ev_illop` 14, `ev_cfg_mismatch` 9, `ev_ext_pin` 7, `ev_sw_reset` 6, `ev_wdt_timeout` 4, `ev_wake_sleep` 3, `ev_wake_idle` 2, `ev_brownout` 1.
- R3: A flag that gets no strobe, no write and no `rst` keeps its value. An event sets only its own flag and leaves the other flags unchanged.
- R4: A `wr_en` cycle writes `wr_data` into every flag bit (15, 14, 9, 7, 6, 4, 3, 2, 1, 0), whether the value is 0 or 1. Writing a 1 only changes the stored bit.
- R5: When a strobe and a write of 0 reach the same flag in the same cycle, the flag ends at 1.
- R6: Bits 12 to 10 always read 0, whatever is written to them.
- R7: Bit 5 is the software watchdog enable; it is writable and resets to 0. `wdt_en` equals `fuse_wdt_on` OR bit 5, and it updates at the same edge as the bit.
- R8: When `bor_mode` is 2'b01, bit 13 is writable and `bor_en` equals bit 13.
- R9: When `bor_mode` is not 2'b01, bit 13 reads 0 and writes to it have no effect. `bor_en` is 0 for mode 2'b00 and 1 for modes 2'b10 and 2'b11.
- R10: Bit 8 is writable and resets to 0. `pm_sleep_pwr` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on event |
| ev_trap | input | 1 | Trap-conflict reset strobe |
| ev_illop | input | 1 | Illegal-opcode / bad-pointer reset strobe |
| ev_cfg_mismatch | input | 1 | Configuration-mismatch reset strobe |
| ev_ext_pin | input | 1 | External pin reset strobe |
| ev_sw_reset | input | 1 | Software reset instruction strobe |
| ev_wdt_timeout | input | 1 | Watchdog timeout strobe |
| ev_wake_sleep | input | 1 | Wake-from-sleep strobe |
| ev_wake_idle | input | 1 | Wake-from-idle strobe |
| ev_brownout | input | 1 | Brown-out reset strobe |
| fuse_wdt_on | input | 1 | Watchdog always-on fuse |
| bor_mode | input | 2 | Brown-out fuse mode: 00 off, 01 software, 1x on |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| wdt_en | output | 1 | Effective watchdog enable (registered) |
| bor_en | output | 1 | Effective brown-out enable (registered) |
| pm_sleep_pwr | output | 1 | Program memory powered in sleep |

## Verification
The assertions check on every cycle that:
- strobes set flags;
- idle flags hold;
- writes land;
- a strobe beats a write of 0;
- the unused bits stay at 0;
- the outputs follow the fuse and software-enable rules whenever the fuses are steady.

Only the bench scenarios can show three other behaviours. One is that `rst` itself overrides a strobe raised in the same cycle. Another is that a change of brown-out mode clears the software brown-out bit so that it stays cleared. The last is that several strobes at once each reach the right bit position.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int REG_W    = 16;
  localparam int MODE_W   = 2;
  localparam int N_FLAGS  = 10;

  localparam int B_BORSW  = 13;
  localparam int B_PMSLP  = 8;
  localparam int B_WDTSW  = 5;

  localparam logic [REG_W-1:0] FLAG_MASK = 16'hC2DF;
  localparam logic [REG_W-1:0] PON_VALUE = 16'h0003;

  typedef enum logic [MODE_W-1:0] {
    BORM_OFF  = 2'b00,
    BORM_SW   = 2'b01,
    BORM_ON   = 2'b10,
    BORM_ON_B = 2'b11
  } bor_mode_e;

  // Flag index -> register bit. Index 0 (power-on) has no strobe.
  function automatic int flag_pos(input int idx);
    case (idx)
      0: flag_pos = 0;   // power-on
      1: flag_pos = 1;   // brown-out
      2: flag_pos = 2;   // wake from idle
      3: flag_pos = 3;   // wake from sleep
      4: flag_pos = 4;   // watchdog timeout
      5: flag_pos = 6;   // software reset
      6: flag_pos = 7;   // external pin
      7: flag_pos = 9;   // config mismatch
      8: flag_pos = 14;  // illegal opcode
      default: flag_pos = 15; // trap conflict
    endcase
  endfunction
endpackage

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic we_i,
  input  logic wd_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= INIT;
    else if (set_i) q_o <= 1'b1;   // hardware set beats software write
    else if (we_i)  q_o <= wd_i;
  end
endmodule

// File: rtl/rcr_enable_ctrl.sv
module rcr_enable_ctrl
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wd_borsw,
  input  logic              wd_wdtsw,
  input  logic              wd_pm,
  input  logic              fuse_wdt_on,
  input  logic [MODE_W-1:0] bor_mode,
  output logic              borsw_rd,
  output logic              wdtsw_q,
  output logic              pm_q,
  output logic              wdt_en_o,
  output logic              bor_en_o
);
  logic sw_mode;
  logic borsw_q, borsw_d, wdtsw_d;

  assign sw_mode = (bor_mode == BORM_SW);

  always_comb begin
    if (!sw_mode)   borsw_d = 1'b0;
    else if (wr_en) borsw_d = wd_borsw;
    else            borsw_d = borsw_q;
    wdtsw_d = wr_en ? wd_wdtsw : wdtsw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      borsw_q  <= sw_mode;
      wdtsw_q  <= 1'b0;
      pm_q     <= 1'b0;
      wdt_en_o <= fuse_wdt_on;
      bor_en_o <= sw_mode | bor_mode[1];
    end else begin
      borsw_q  <= borsw_d;
      wdtsw_q  <= wdtsw_d;
      if (wr_en) pm_q <= wd_pm;
      wdt_en_o <= fuse_wdt_on | wdtsw_d;
      bor_en_o <= sw_mode ? borsw_d : bor_mode[1];
    end
  end

  assign borsw_rd = borsw_q & sw_mode;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_trap,
  input  logic              ev_illop,
  input  logic              ev_cfg_mismatch,
  input  logic              ev_ext_pin,
  input  logic              ev_sw_reset,
  input  logic              ev_wdt_timeout,
  input  logic              ev_wake_sleep,
  input  logic              ev_wake_idle,
  input  logic              ev_brownout,
  input  logic              fuse_wdt_on,
  input  logic [MODE_W-1:0] bor_mode,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              wdt_en,
  output logic              bor_en,
  output logic              pm_sleep_pwr
);
  logic [N_FLAGS-1:0] evt;
  logic [N_FLAGS-1:0] flag_q;
  logic borsw_rd, wdtsw_q;
  logic unused_wbits;

  assign evt = {ev_trap, ev_illop, ev_cfg_mismatch, ev_ext_pin, ev_sw_reset,
                ev_wdt_timeout, ev_wake_sleep, ev_wake_idle, ev_brownout, 1'b0};
  assign unused_wbits = ^wr_data[12:10];

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    rcr_flag_cell #(.INIT(PON_VALUE[POS])) u_cell (
      .clk  (clk),
      .rst  (rst),
      .set_i(evt[i]),
      .we_i (wr_en),
      .wd_i (wr_data[POS]),
      .q_o  (flag_q[i])
    );
  end

  rcr_enable_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wd_borsw   (wr_data[B_BORSW]),
    .wd_wdtsw   (wr_data[B_WDTSW]),
    .wd_pm      (wr_data[B_PMSLP]),
    .fuse_wdt_on(fuse_wdt_on),
    .bor_mode   (bor_mode),
    .borsw_rd   (borsw_rd),
    .wdtsw_q    (wdtsw_q),
    .pm_q       (pm_sleep_pwr),
    .wdt_en_o   (wdt_en),
    .bor_en_o   (bor_en)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_FLAGS; i++) rd_data[flag_pos(i)] = flag_q[i];
    rd_data[B_BORSW] = borsw_rd;
    rd_data[B_PMSLP] = pm_sleep_pwr;
    rd_data[B_WDTSW] = wdtsw_q;
  end
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rcr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_trap,
  input logic              ev_illop,
  input logic              ev_cfg_mismatch,
  input logic              ev_ext_pin,
  input logic              ev_sw_reset,
  input logic              ev_wdt_timeout,
  input logic              ev_wake_sleep,
  input logic              ev_wake_idle,
  input logic              ev_brownout,
  input logic              fuse_wdt_on,
  input logic [MODE_W-1:0] bor_mode,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic              wdt_en,
  input logic              bor_en,
  input logic              pm_sleep_pwr
);
  logic any_ev;
  assign any_ev = ev_trap | ev_illop | ev_cfg_mismatch | ev_ext_pin | ev_sw_reset |
                  ev_wdt_timeout | ev_wake_sleep | ev_wake_idle | ev_brownout;

  p_pon_value_r1: assert property (@(posedge clk)
    rst |=> ((rd_data & ~(16'h1 << B_BORSW)) == PON_VALUE));

  p_trap_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_trap |=> rd_data[15]);
  p_illop_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_illop |=> rd_data[14]);
  p_wdto_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_wdt_timeout |=> rd_data[4]);
  p_bor_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_brownout |=> rd_data[1]);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !any_ev) |=> $stable(rd_data & FLAG_MASK));

  p_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !any_ev) |=> ((rd_data & FLAG_MASK) == ($past(wr_data) & FLAG_MASK)));

  p_hw_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_ext_pin && wr_en && !wr_data[7]) |=> rd_data[7]);

  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[12:10] == 3'b000);

  p_wdt_rule_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(fuse_wdt_on) |-> (wdt_en == (fuse_wdt_on | rd_data[B_WDTSW])));

  p_bor_sw_r8: assert property (@(posedge clk) disable iff (rst)
    ($stable(bor_mode) && bor_mode == 2'b01) |-> (bor_en == rd_data[B_BORSW]));

  p_bor_forced_r9: assert property (@(posedge clk) disable iff (rst)
    ($stable(bor_mode) && bor_mode != 2'b01) |-> (!rd_data[B_BORSW] && bor_en == bor_mode[1]));

  p_pm_write_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pm_sleep_pwr == $past(wr_data[B_PMSLP])));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (.*);

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  typedef struct {
    logic [15:0] rd;
    logic        wdt;
    logic        bor;
    logic        pm;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] ev = '0;   // {trap,illop,cfgmm,ext,swrst,wdto,wslp,widle,bor}
  logic fuse_wdt = 1'b0;
  logic [1:0] mode = 2'b01;
  logic we = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic wdt_en, bor_en, pm;
  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  rst_cause_reg u0 (
    .clk(clk), .rst(rst),
    .ev_trap(ev[8]), .ev_illop(ev[7]), .ev_cfg_mismatch(ev[6]), .ev_ext_pin(ev[5]),
    .ev_sw_reset(ev[4]), .ev_wdt_timeout(ev[3]), .ev_wake_sleep(ev[2]),
    .ev_wake_idle(ev[1]), .ev_brownout(ev[0]),
    .fuse_wdt_on(fuse_wdt), .bor_mode(mode), .wr_en(we), .wr_data(wd),
    .rd_data(rd), .wdt_en(wdt_en), .bor_en(bor_en), .pm_sleep_pwr(pm)
  );

  task automatic step(input logic r, input logic [8:0] e, input logic w,
                      input logic [15:0] d, input logic fw, input logic [1:0] m,
                      input logic [15:0] xrd, input logic xw, input logic xb,
                      input logic xp, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; ev = e; we = w; wd = d; fuse_wdt = fw; mode = m;
    it.rd = xrd; it.wdt = xw; it.bor = xb; it.pm = xp; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic cmp(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per edge and compares
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      cmp(it.tag, "rd_data", rd, it.rd);
      cmp(it.tag, "wdt_en", {15'd0, wdt_en}, {15'd0, it.wdt});
      cmp(it.tag, "bor_en", {15'd0, bor_en}, {15'd0, it.bor});
      cmp(it.tag, "pm_sleep_pwr", {15'd0, pm}, {15'd0, it.pm});
    end
  end

  initial begin
    step(1, 9'h000, 0, 16'h0000, 0, 2'b01, 16'h2003, 0, 1, 0, "R1 power-on value");
    step(0, 9'h100, 0, 16'h0000, 0, 2'b01, 16'hA003, 0, 1, 0, "R2 trap flag");
    step(0, 9'h020, 0, 16'h0000, 0, 2'b01, 16'hA083, 0, 1, 0, "R3 ext flag, others kept");
    step(0, 9'h000, 0, 16'h0000, 0, 2'b01, 16'hA083, 0, 1, 0, "R3 idle hold");
    step(0, 9'h008, 1, 16'h0000, 0, 2'b01, 16'h0010, 0, 0, 0, "R5 hw set beats write0");
    step(0, 9'h000, 1, 16'hFFFF, 0, 2'b01, 16'hE3FF, 1, 1, 1, "R4 R6 R7 R8 R10 write ones");
    step(0, 9'h000, 1, 16'h0000, 0, 2'b01, 16'h0000, 0, 0, 0, "R4 write zeros");
    step(0, 9'h0D7, 0, 16'h0000, 0, 2'b01, 16'h424E, 0, 0, 0, "R2 multi strobe");
    step(0, 9'h000, 0, 16'h0000, 1, 2'b01, 16'h424E, 1, 0, 0, "R7 fuse forces wdt");
    step(0, 9'h000, 1, 16'h2000, 1, 2'b00, 16'h0000, 1, 0, 0, "R9 mode off ignores bit13");
    step(0, 9'h000, 0, 16'h0000, 1, 2'b10, 16'h0000, 1, 1, 0, "R9 mode on");
    step(1, 9'h000, 0, 16'h0000, 1, 2'b10, 16'h0003, 1, 1, 0, "R1 power-on mode on");
    step(1, 9'h000, 0, 16'h0000, 0, 2'b01, 16'h2003, 0, 1, 0, "R1 power-on mode sw");
    step(1, 9'h020, 0, 16'h0000, 0, 2'b01, 16'h2003, 0, 1, 0, "R1 reset overrides strobe");
    step(0, 9'h000, 1, 16'h1C20, 0, 2'b01, 16'h0020, 1, 0, 0, "R6 R7 unimpl ignored, sw wdt");
    step(0, 9'h000, 1, 16'h0100, 0, 2'b01, 16'h0100, 0, 0, 1, "R10 pm bit");
    @(negedge clk); we = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule